// File: doc/BRIEF.md
# Channel-Pair Sequencer with Burst Conversion

This controller steps a two-channel simultaneous-sampling converter through a short stack of programmed channel-pair selections. Each stack slot holds a 4-bit pair code and an end-of-sequence flag. A configuration word holds a sequencer enable and a burst enable. In step mode every convert-start pulse converts one slot. In burst mode a single pulse runs every remaining slot back to back, with acquisition gaps between them. The selected pair code is driven on `chsel` for the whole conversion. Conversion and acquisition times are modelled as cycle counts.

Each finished conversion captures the two samples on `adc_a`/`adc_b` into a result queue. The queue keeps conversion order and is read one slot per read strobe once `busy` is low. A strap mode, latched while full reset is held, replaces the software configuration with pin levels. In that mode the channel-pair code can be changed by holding new pin levels steady across a whole busy pulse. A partial reset rewinds the sequence and keeps everything that was programmed.

Top module: `chan_seq_ctrl`

## Requirements
- R1: When a slot whose end flag is set finishes converting with the sequencer enabled, the next conversion uses slot 0. The last stack slot also wraps to slot 0.
- R2: The first accepted convert-start after the enable bit changes from 0 to 1 is a dummy. It keeps `busy` high for CONV_CYC cycles, queues no result and does not move the slot pointer.
- R3: In step mode an accepted rising edge of `convst` sets `busy` for exactly CONV_CYC cycles. During that time `chsel` shows the current slot's code, and the pointer then advances by one slot.
- R4: With sequencer and burst both enabled, one rising edge converts slots from the pointer up to the end slot. `busy` stays high for CONV_CYC + (N-1)*(ACQ_CYC+CONV_CYC) cycles, where N is the number of slots converted.
- R5: Results come out in conversion order, one read per converted slot, as `rd_data[31:16]`=`adc_a` and `rd_data[15:0]`=`adc_b` sampled in the conversion's last cycle. A read with no result left gives no `rd_valid`.
- R6: `part_rst` returns the pointer to slot 0, stops any conversion and empties the result queue. It leaves the stack slots and the configuration unchanged.
- R7: The strap-mode select, the enable and the burst levels are captured while `rst` is high and stay fixed until the next full reset. In strap mode, writes to the configuration port are ignored.
- R8: In strap mode the pair code captured at reset is used at first. Pin levels that stay unchanged through a whole busy pulse become the code after that pulse. If the pins change during the pulse, the code is kept.
- R9: A rising edge of `convst` while `busy` is high is ignored. It neither lengthens the busy pulse nor starts a further conversion.
- R10: A read strobe while `busy` is high pops nothing, leaves `rd_data` unchanged, gives no `rd_valid`, and raises `rd_err` for one cycle.
- R11: Full reset clears every slot to code 0 with no end flag, clears enable and burst, empties the queue, and sets `busy`, `rd_data`, `rd_valid` and `rd_err` to 0.
- R12: With the enable bit clear, every conversion uses slot 0 for exactly CONV_CYC cycles, whatever the burst bit holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Full synchronous reset, active high; strap pins are captured while it is high |
| part_rst | input | 1 | Partial reset: rewind the pointer and empty the queue |
| strap_mode | input | 1 | Selects pin configuration when captured at reset |
| pin_seq_en | input | 1 | Strap-mode sequencer enable |
| pin_burst | input | 1 | Strap-mode burst enable |
| pin_chsel | input | 4 | Strap-mode channel-pair code |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | clog2(DEPTH)+1 | MSB=1 selects the config word; otherwise the low bits select a stack slot |
| cfg_wdata | input | 5 | Slot: bit 4 end flag, bits 3:0 code. Config: bit 0 enable, bit 1 burst |
| convst | input | 1 | Convert start, acted on at its rising edge |
| adc_a | input | 16 | Sample of the first converter |
| adc_b | input | 16 | Sample of the second converter |
| rd_en | input | 1 | Read strobe for the result queue |
| busy | output | 1 | High while a conversion or burst is in progress |
| chsel | output | 4 | Channel-pair code being converted |
| rd_data | output | 32 | Last result read |
| rd_valid | output | 1 | One-cycle pulse when `rd_data` takes a new result |
| rd_err | output | 1 | One-cycle pulse after a read attempted during `busy` |

## Verification
A wrong slot pointer shows on `chsel` within the busy pulse of the very next conversion. It also shows as a misordered result when that slot is read back, so wrap, dummy and rewind faults appear within one conversion. A miscounted conversion or acquisition timer shows as a busy pulse of the wrong length, which the bench measures cycle by cycle for step, dummy and burst runs. A faulty strap capture or select-tracking register shows on `chsel` at the next conversion after reset or after the busy pulse in question.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int CODE_W = 4;
    localparam int SAMP_W = 16;

    typedef struct packed {
        logic              last;
        logic [CODE_W-1:0] code;
    } step_t;

    typedef struct packed {
        logic [SAMP_W-1:0] a;
        logic [SAMP_W-1:0] b;
    } pair_t;

    typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_ACQ} st_e;
endpackage

// File: rtl/seq_cfg.sv
module seq_cfg
    import seq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH),
    localparam int AW = IW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_mode,
    input  logic              pin_seq_en,
    input  logic              pin_burst,
    input  logic [CODE_W-1:0] pin_chsel,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [CODE_W:0]   cfg_wdata,
    input  logic              start,
    input  logic              busy,
    input  logic [IW-1:0]     idx,
    output step_t             step_o,
    output logic              seq_en,
    output logic              burst_en,
    output logic              dummy_set
);
    logic              strap_q, en_q, burst_q, mism_q, busy_q;
    logic [CODE_W-1:0] sel_q, cand_q;
    step_t             stack_q [DEPTH];
    logic              wr_ok;

    assign wr_ok     = cfg_we & ~strap_q;
    assign dummy_set = wr_ok & cfg_addr[AW-1] & cfg_wdata[0] & ~en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strap_q <= strap_mode;
            en_q    <= strap_mode & pin_seq_en;
            burst_q <= strap_mode & pin_burst;
            sel_q   <= strap_mode ? pin_chsel : '0;
            cand_q  <= '0;
            mism_q  <= 1'b0;
            busy_q  <= 1'b0;
            for (int i = 0; i < DEPTH; i++) stack_q[i] <= '0;
        end else begin
            busy_q <= busy;
            if (wr_ok) begin
                if (cfg_addr[AW-1]) begin
                    en_q    <= cfg_wdata[0];
                    burst_q <= cfg_wdata[1];
                end else begin
                    stack_q[cfg_addr[IW-1:0]] <= step_t'(cfg_wdata);
                end
            end
            if (strap_q) begin
                if (start) begin
                    cand_q <= pin_chsel;
                    mism_q <= 1'b0;
                end else if (busy && (pin_chsel != cand_q)) begin
                    mism_q <= 1'b1;
                end
                if (busy_q && !busy && !mism_q) sel_q <= cand_q;
            end
        end
    end

    always_comb begin
        if (strap_q) begin
            step_o.last = 1'b1;
            step_o.code = sel_q;
        end else begin
            step_o = stack_q[idx];
        end
    end

    assign seq_en   = en_q;
    assign burst_en = burst_q;

    AST_STRAP_FIXED: assert property (@(posedge clk) disable iff (rst)
        strap_q |=> ($stable(en_q) && $stable(burst_q) && strap_q)) else $error("strap cfg changed"); // R7
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import seq_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int CONV_CYC = 8,
    parameter int ACQ_CYC  = 4,
    localparam int IW    = $clog2(DEPTH),
    localparam int CMAX  = (CONV_CYC > ACQ_CYC) ? CONV_CYC : ACQ_CYC,
    localparam int CNT_W = $clog2(CMAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          part_rst,
    input  logic          convst,
    input  logic          seq_en,
    input  logic          burst_en,
    input  logic          dummy_set,
    input  logic          step_last,
    output logic          busy,
    output logic          start,
    output logic          push,
    output logic [IW-1:0] cur
);
    st_e              st;
    logic [CNT_W-1:0] cnt;
    logic [IW-1:0]    ptr, nxt;
    logic             cv_q, dummy, dummy_pend, rise, conv_done, wrap;

    assign rise      = convst & ~cv_q;
    assign start     = (st == ST_IDLE) & rise & ~part_rst;
    assign conv_done = (st == ST_CONV) && (cnt == '0);
    assign wrap      = step_last || (cur == IW'(DEPTH - 1));
    assign nxt       = wrap ? '0 : cur + 1'b1;
    assign push      = conv_done & ~dummy & ~part_rst;
    assign busy      = (st != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE; cnt <= '0; ptr <= '0; cur <= '0;
            cv_q <= 1'b0; dummy <= 1'b0; dummy_pend <= 1'b0;
        end else begin
            cv_q <= convst;
            if (dummy_set) dummy_pend <= 1'b1;
            if (part_rst) begin
                st <= ST_IDLE; cnt <= '0; ptr <= '0; cur <= '0; dummy <= 1'b0;
            end else begin
                unique case (st)
                    ST_IDLE: if (rise) begin
                        st    <= ST_CONV;
                        cnt   <= CNT_W'(CONV_CYC - 1);
                        cur   <= seq_en ? ptr : '0;
                        dummy <= dummy_pend & seq_en;
                        if (seq_en) dummy_pend <= 1'b0;
                    end
                    ST_CONV: if (cnt == '0) begin
                        if (!dummy && seq_en) ptr <= nxt;
                        if (!dummy && seq_en && burst_en && !wrap) begin
                            st  <= ST_ACQ;
                            cnt <= CNT_W'(ACQ_CYC - 1);
                            cur <= nxt;
                        end else begin
                            st <= ST_IDLE;
                        end
                        dummy <= 1'b0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                    ST_ACQ: if (cnt == '0) begin
                        st  <= ST_CONV;
                        cnt <= CNT_W'(CONV_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    AST_WRAP_LAST: assert property (@(posedge clk) disable iff (rst)
        (conv_done && !dummy && seq_en && step_last && !part_rst) |=> (ptr == '0)) else $error("no wrap"); // R1
    AST_DUMMY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (conv_done && dummy && !part_rst) |=> $stable(ptr)) else $error("dummy moved ptr"); // R2
    AST_PART_REWIND: assert property (@(posedge clk) disable iff (rst)
        part_rst |=> (ptr == '0 && !busy)) else $error("partial reset"); // R6
    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (rst)
        (busy && rise && !conv_done && !part_rst) |=> busy) else $error("retrigger"); // R9
endmodule

// File: rtl/seq_fifo.sv
module seq_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 32,
    localparam int IW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         busy,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         rd_valid,
    output logic         rd_err
);
    logic [W-1:0]  mem [DEPTH];
    logic [IW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign do_push = push && (cnt != CW'(DEPTH));
    assign do_pop  = rd_en && !busy && (cnt != '0) && !clr;

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0; rp <= '0; cnt <= '0;
            rd_data <= '0; rd_valid <= 1'b0; rd_err <= 1'b0;
        end else begin
            rd_valid <= do_pop;
            rd_err   <= rd_en && busy && !clr;
            if (clr) begin
                wp <= '0; rp <= '0; cnt <= '0;
            end else begin
                if (do_push) begin
                    wp  <= (wp == IW'(DEPTH - 1)) ? '0 : wp + 1'b1;
                    cnt <= cnt + 1'b1;
                end
                if (do_pop) begin
                    rd_data <= mem[rp];
                    rp      <= (rp == IW'(DEPTH - 1)) ? '0 : rp + 1'b1;
                    cnt     <= cnt - 1'b1;
                end
            end
        end
    end

    AST_RD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (rd_en && busy && !clr) |=> (rd_err && !rd_valid && $stable(rd_data))) else $error("busy read"); // R10
    AST_PUSH_BUSY: assert property (@(posedge clk) disable iff (rst)
        push |-> busy) else $error("push outside busy"); // R4
endmodule

// File: rtl/chan_seq_ctrl.sv
module chan_seq_ctrl
    import seq_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int CONV_CYC = 8,
    parameter int ACQ_CYC  = 4,
    localparam int IW = $clog2(DEPTH),
    localparam int AW = IW + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                part_rst,
    input  logic                strap_mode,
    input  logic                pin_seq_en,
    input  logic                pin_burst,
    input  logic [CODE_W-1:0]   pin_chsel,
    input  logic                cfg_we,
    input  logic [AW-1:0]       cfg_addr,
    input  logic [CODE_W:0]     cfg_wdata,
    input  logic                convst,
    input  logic [SAMP_W-1:0]   adc_a,
    input  logic [SAMP_W-1:0]   adc_b,
    input  logic                rd_en,
    output logic                busy,
    output logic [CODE_W-1:0]   chsel,
    output logic [2*SAMP_W-1:0] rd_data,
    output logic                rd_valid,
    output logic                rd_err
);
    step_t         step;
    logic          seq_en, burst_en, dummy_set, start, push;
    logic [IW-1:0] cur;
    pair_t         sample;

    assign sample.a = adc_a;
    assign sample.b = adc_b;
    assign chsel    = step.code;

    seq_cfg #(.DEPTH(DEPTH)) u_cfg (
        .clk(clk), .rst(rst), .strap_mode(strap_mode), .pin_seq_en(pin_seq_en),
        .pin_burst(pin_burst), .pin_chsel(pin_chsel), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .start(start), .busy(busy),
        .idx(cur), .step_o(step), .seq_en(seq_en), .burst_en(burst_en),
        .dummy_set(dummy_set)
    );

    seq_fsm #(.DEPTH(DEPTH), .CONV_CYC(CONV_CYC), .ACQ_CYC(ACQ_CYC)) u_fsm (
        .clk(clk), .rst(rst), .part_rst(part_rst), .convst(convst),
        .seq_en(seq_en), .burst_en(burst_en), .dummy_set(dummy_set),
        .step_last(step.last), .busy(busy), .start(start), .push(push), .cur(cur)
    );

    seq_fifo #(.DEPTH(DEPTH), .W(2*SAMP_W)) u_fifo (
        .clk(clk), .rst(rst), .clr(part_rst), .busy(busy), .push(push),
        .push_data(sample), .rd_en(rd_en), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_err(rd_err)
    );
endmodule

// File: tb/tb_chan_seq_ctrl.sv
`timescale 1ns/1ps
module tb_chan_seq_ctrl;
    localparam int DEPTH = 8, CONV = 8, ACQ = 4;

    logic clk = 0, rst = 1, part_rst = 0, strap_mode = 0, pin_seq_en = 0, pin_burst = 0;
    logic [3:0] pin_chsel = 0;
    logic cfg_we = 0;
    logic [3:0] cfg_addr = 0;
    logic [4:0] cfg_wdata = 0;
    logic convst = 0, rd_en = 0;
    logic [15:0] adc_a, adc_b;
    logic busy, rd_valid, rd_err;
    logic [3:0] chsel;
    logic [31:0] rd_data;

    int errors = 0, checks = 0;
    logic [31:0] exp_q[$];
    logic [31:0] last_rd = 0;

    always #2 clk = ~clk;

    assign adc_a = 16'hA000 | {12'h0, chsel};
    assign adc_b = 16'hB000 | {12'h0, chsel};

    chan_seq_ctrl #(.DEPTH(DEPTH), .CONV_CYC(CONV), .ACQ_CYC(ACQ)) dut (
        .clk(clk), .rst(rst), .part_rst(part_rst), .strap_mode(strap_mode),
        .pin_seq_en(pin_seq_en), .pin_burst(pin_burst), .pin_chsel(pin_chsel),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .convst(convst),
        .adc_a(adc_a), .adc_b(adc_b), .rd_en(rd_en), .busy(busy), .chsel(chsel),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_err(rd_err)
    );

    function automatic logic [31:0] res(input logic [3:0] c);
        return {16'hA000 | {12'h0, c}, 16'hB000 | {12'h0, c}};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a result is delivered
    always @(negedge clk) begin
        if (rd_valid) begin
            if (exp_q.size() == 0) check(0, "R5 unexpected result", rd_data, 0);
            else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check(rd_data == e, "R5 result order", rd_data, e);
            end
            last_rd = rd_data;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [4:0] d);
        @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic pulse_part;
        @(negedge clk); part_rst = 1;
        @(negedge clk); part_rst = 0;
    endtask

    task automatic rd_one;
        @(negedge clk); rd_en = 1;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic rd_none(input string tag);
        @(negedge clk); rd_en = 1;
        @(negedge clk); rd_en = 0;
        check(rd_valid == 0, tag, {31'h0, rd_valid}, 0);
    endtask

    // driver: start a conversion, check chsel and busy length; extra stimulus while busy
    task automatic conv(input int exp_len, input logic [3:0] exp_code, input string tag,
                        input bit poke, input bit pin_flip);
        int n;
        n = 0;
        @(negedge clk); convst = 1;
        @(negedge clk); convst = 0;
        check(chsel == exp_code, {tag, " chsel"}, {28'h0, chsel}, {28'h0, exp_code});
        while (busy && n < 200) begin
            n++;
            if (poke && n == 2) convst = 1;
            if (poke && n == 3) convst = 0;
            if (poke && n == 4) rd_en = 1;
            if (poke && n == 5) begin
                rd_en = 0;
                check(rd_err == 1 && rd_valid == 0, "R10 busy read flag", {30'h0, rd_err, rd_valid}, 2);
                check(rd_data == last_rd, "R10 data held", rd_data, last_rd);
            end
            if (pin_flip && n == 3) pin_chsel = 4'hE;
            @(negedge clk);
        end
        check(n == exp_len, {tag, " busy length"}, n, exp_len);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11 reset state
        check(busy == 0 && rd_valid == 0 && rd_err == 0, "R11 flags", {29'h0, busy, rd_valid, rd_err}, 0);
        check(rd_data == 0 && chsel == 0, "R11 data", rd_data, 0);

        // R12: disabled sequencer ignores burst, converts slot 0
        wr(4'h8, 5'b00010);
        conv(CONV, 4'h0, "R12", 0, 0); exp_q.push_back(res(4'h0)); rd_one();

        // program three-slot sequence, end flag on slot 2
        wr(4'h0, 5'h03); wr(4'h1, 5'h05); wr(4'h2, 5'h19);
        wr(4'h8, 5'b00001);
        // R2 dummy
        conv(CONV, 4'h3, "R2 dummy", 0, 0);
        rd_none("R2 no result from dummy");
        // R1/R3 stepping with wrap
        conv(CONV, 4'h3, "R3 step0", 0, 0); exp_q.push_back(res(4'h3)); rd_one();
        conv(CONV, 4'h5, "R3 step1", 0, 0); exp_q.push_back(res(4'h5)); rd_one();
        conv(CONV, 4'h9, "R3 step2", 0, 0); exp_q.push_back(res(4'h9)); rd_one();
        conv(CONV, 4'h3, "R1 wrap", 0, 0);  exp_q.push_back(res(4'h3));
        // R9/R10: retrigger and read while busy
        conv(CONV, 4'h5, "R9 retrigger", 1, 0); exp_q.push_back(res(4'h5));
        repeat (3) @(negedge clk);
        check(busy == 0, "R9 no extra conversion", {31'h0, busy}, 0);
        rd_one(); rd_one();
        rd_none("R9 only one result");

        // R6 partial reset rewinds, keeps program
        pulse_part();
        conv(CONV, 4'h3, "R6 rewind", 0, 0); exp_q.push_back(res(4'h3)); rd_one();

        // R4 burst
        pulse_part();
        wr(4'h8, 5'b00011);
        conv(CONV + 2 * (ACQ + CONV), 4'h3, "R4 burst", 0, 0);
        exp_q.push_back(res(4'h3)); exp_q.push_back(res(4'h5)); exp_q.push_back(res(4'h9));
        rd_one(); rd_one(); rd_one();
        rd_none("R5 reads equal sequence length");
        check(exp_q.size() == 0, "R5 all results read", exp_q.size(), 0);

        // R7/R8 strap mode
        @(negedge clk); rst = 1; strap_mode = 1; pin_seq_en = 1; pin_burst = 0; pin_chsel = 4'h6;
        repeat (2) @(negedge clk);
        rst = 0; strap_mode = 0; pin_chsel = 4'hC;
        wr(4'h0, 5'h01);
        conv(CONV, 4'h6, "R7 strap latched", 0, 0); exp_q.push_back(res(4'h6)); rd_one();
        conv(CONV, 4'hC, "R8 steady pins adopted", 0, 0); exp_q.push_back(res(4'hC)); rd_one();
        @(negedge clk); pin_chsel = 4'hD;
        conv(CONV, 4'hC, "R8 moving pins", 0, 1); exp_q.push_back(res(4'hC)); rd_one();
        conv(CONV, 4'hC, "R8 code kept", 0, 0); exp_q.push_back(res(4'hC)); rd_one();
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule